// File: doc/BRIEF.md
# Stage-1 Address Pre-Translation Checker

This unit sits in front of the stage-1 translation lookup. Each cycle it may take one virtual address with its context: whether the request comes from the unprivileged level, the kind of access, whether the TLB already holds a matching entry, and the 64-bit translation control word. Address bit 55 picks one of two translation regions, lower or upper. The unit then reads that region's controls from the control word. It decides whether the top address byte is a tag to be dropped, and checks that the address falls inside the region's span.

One cycle later it reports a single outcome. The outcome is a translation fault with its cause, a silent failure for a non-faulting access, or a request to walk the tables of the selected region. The unit also returns the normalised address. For branch targets headed to the program counter, it only corrects the top byte to match bit 55 and raises nothing.

Top module: `va_precheck`

## Requirements
- R1: Address bit 55 selects the region. 0 uses the lower controls: tag-drop bit 37, fetch-exclusion bit 51, unprivileged-block bit 55, non-fault walk-off bit 53, walk-off bit 7, size offset [5:0]. 1 uses the upper controls: bits 38, 52, 56, 54, 23 and [21:16]. `region_hi` reports the selection.
- R2: For a size offset S, the region spans 2^(64-S) bytes. When tag dropping is not in effect, bits [63:64-S] must all equal bit 55. Otherwise `fault_valid` is raised with `fault_cause` = 1 (range). S = 0 accepts every address.
- R3: When the region's tag-drop bit applies, bits [63:56] are left out of the range check. `out_addr` then carries bits [63:56] replaced by copies of bit 55. When the tag-drop bit does not apply, `out_addr` equals the input address.
- R4: When the region's fetch-exclusion bit is 1, tag dropping applies to data and non-fault accesses only. Instruction fetches (`in_kind` = 1) and branch targets (`in_kind` = 3) use the full address. `in_kind` 0 is data and 2 is non-fault.
- R5: An access with `in_el0` = 1 to a region whose unprivileged-block bit is 1 raises a fault with cause 2.
- R6: On a TLB miss to a region whose walk-off bit is 1, a fault with cause 3 is raised and no walk is requested.
- R7: On a TLB miss by a non-fault access to a region whose non-fault walk-off bit is 1, `nf_fail` is raised with no fault and no walk.
- R8: Priority from highest to lowest is range, unprivileged block, walk-off, non-fault walk-off. At most one of `fault_valid`, `nf_fail` and `walk_req` is high. `walk_req` is raised only on a miss with none of these conditions, and a hit raises nothing.
- R9: A branch target (`in_kind` = 3) produces the normalised address and raises no fault, no `nf_fail` and no `walk_req`.
- R10: Outputs appear one cycle after `in_valid`. With no valid input, `out_valid`, all flags, `fault_cause`, `region_hi` and `out_addr` are 0. Reset clears the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_va | input | 64 | Virtual address |
| in_el0 | input | 1 | 1 = unprivileged requester |
| in_kind | input | 2 | 0 data, 1 fetch, 2 non-fault, 3 branch target |
| in_tlb_hit | input | 1 | TLB already holds the translation |
| in_cfg | input | 64 | Translation control word |
| out_valid | output | 1 | Result present |
| fault_valid | output | 1 | Translation fault (level 0) |
| fault_cause | output | 2 | 1 range, 2 unprivileged block, 3 walk disabled |
| nf_fail | output | 1 | Silent failure of a non-fault access |
| walk_req | output | 1 | Table walk requested |
| region_hi | output | 1 | 1 = upper region selected |
| out_addr | output | 64 | Normalised address |

## Verification
On every cycle, the assertions check the one-cycle latency, the idle outputs and the exclusivity of the three outcomes. They also check that a TLB hit never walks, that an unprivileged request to a blocked region faults, that branch targets stay silent, and that the region select and the low 56 address bits pass through. Only the bench's scenarios can show the exact range boundary for each size offset, the top-byte rewrite under each mix of tag-drop and fetch-exclusion bits, and the priority order between competing causes. The bench's reference model compares every output on every cycle, both in directed cases and in a long random sequence.

// File: rtl/va_precheck_pkg.sv
`timescale 1ns/1ps
package va_precheck_pkg;
    localparam int ADDR_W  = 64;
    localparam int CFG_W   = 64;
    localparam int SZ_W    = 6;
    localparam int SEL_BIT = 55;
    localparam int TAG_LSB = 56;

    // control word positions: lower region / upper region
    localparam int P_TAG_LO  = 37;
    localparam int P_TAG_HI  = 38;
    localparam int P_FEX_LO  = 51;
    localparam int P_FEX_HI  = 52;
    localparam int P_BLK_LO  = 55;
    localparam int P_BLK_HI  = 56;
    localparam int P_NFW_LO  = 53;
    localparam int P_NFW_HI  = 54;
    localparam int P_WOFF_LO = 7;
    localparam int P_WOFF_HI = 23;
    localparam int P_SZ_LO   = 0;
    localparam int P_SZ_HI   = 16;

    typedef enum logic [1:0] {
        ACC_DATA    = 2'd0,
        ACC_FETCH   = 2'd1,
        ACC_NOFAULT = 2'd2,
        ACC_BRANCH  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_RANGE    = 2'd1,
        CAUSE_EL0_BLK  = 2'd2,
        CAUSE_WALK_OFF = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic            tag_drop;
        logic            fetch_excl;
        logic            el0_block;
        logic            nf_walk_off;
        logic            walk_off;
        logic [SZ_W-1:0] size_off;
    } region_ctl_t;

    typedef struct packed {
        logic              valid;
        logic              fault;
        fault_cause_e      cause;
        logic              nf_fail;
        logic              walk;
        logic              region_hi;
        logic [ADDR_W-1:0] addr;
    } result_t;
endpackage

// File: rtl/va_region_sel.sv
`timescale 1ns/1ps
module va_region_sel
    import va_precheck_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             sel_hi,
    output region_ctl_t      ctl
);
    region_ctl_t cand [2];
    logic unused_cfg;

    assign unused_cfg = ^cfg;

    always_comb begin
        cand[0].tag_drop    = cfg[P_TAG_LO];
        cand[0].fetch_excl  = cfg[P_FEX_LO];
        cand[0].el0_block   = cfg[P_BLK_LO];
        cand[0].nf_walk_off = cfg[P_NFW_LO];
        cand[0].walk_off    = cfg[P_WOFF_LO];
        cand[0].size_off    = cfg[P_SZ_LO +: SZ_W];
        cand[1].tag_drop    = cfg[P_TAG_HI];
        cand[1].fetch_excl  = cfg[P_FEX_HI];
        cand[1].el0_block   = cfg[P_BLK_HI];
        cand[1].nf_walk_off = cfg[P_NFW_HI];
        cand[1].walk_off    = cfg[P_WOFF_HI];
        cand[1].size_off    = cfg[P_SZ_HI +: SZ_W];
    end

    assign ctl = sel_hi ? cand[1] : cand[0];
endmodule

// File: rtl/va_bound_check.sv
`timescale 1ns/1ps
module va_bound_check #(
    parameter int ADDR_W  = 64,
    parameter int SZ_W    = 6,
    parameter int SEL_BIT = 55,
    parameter int TAG_LSB = 56
) (
    input  logic [ADDR_W-1:0] va,
    input  logic [SZ_W-1:0]   size_off,
    input  logic              tag_drop,
    output logic              out_of_range
);
    localparam int LIM_W = SZ_W + 1;

    logic [LIM_W-1:0]  lo_bit;
    logic [ADDR_W-1:0] mism;

    assign lo_bit = LIM_W'(ADDR_W) - {1'b0, size_off};

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        logic above_span;
        logic in_scope;
        assign above_span = (LIM_W'(i) >= lo_bit);
        assign in_scope   = (i < TAG_LSB) ? 1'b1 : !tag_drop;
        assign mism[i]    = above_span && in_scope && (va[i] != va[SEL_BIT]);
    end

    assign out_of_range = |mism;
endmodule

// File: rtl/va_precheck.sv
`timescale 1ns/1ps
module va_precheck
    import va_precheck_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_va,
    input  logic              in_el0,
    input  logic [1:0]        in_kind,
    input  logic              in_tlb_hit,
    input  logic [CFG_W-1:0]  in_cfg,
    output logic              out_valid,
    output logic              fault_valid,
    output logic [1:0]        fault_cause,
    output logic              nf_fail,
    output logic              walk_req,
    output logic              region_hi,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int TOP_W = ADDR_W - TAG_LSB;

    region_ctl_t ctl;
    acc_kind_e   kind;
    logic        is_fetch;
    logic        drop_eff;
    logic        oor;
    result_t     res_d, res_q;

    assign kind = acc_kind_e'(in_kind);

    va_region_sel u_sel (
        .cfg    (in_cfg),
        .sel_hi (in_va[SEL_BIT]),
        .ctl    (ctl)
    );

    assign is_fetch = (kind == ACC_FETCH) || (kind == ACC_BRANCH);
    assign drop_eff = ctl.tag_drop && !(ctl.fetch_excl && is_fetch);

    va_bound_check #(
        .ADDR_W  (ADDR_W),
        .SZ_W    (SZ_W),
        .SEL_BIT (SEL_BIT),
        .TAG_LSB (TAG_LSB)
    ) u_bound (
        .va           (in_va),
        .size_off     (ctl.size_off),
        .tag_drop     (drop_eff),
        .out_of_range (oor)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid     = 1'b1;
            res_d.region_hi = in_va[SEL_BIT];
            res_d.addr      = drop_eff
                ? {{TOP_W{in_va[SEL_BIT]}}, in_va[TAG_LSB-1:0]}
                : in_va;
            if (kind != ACC_BRANCH) begin
                if (oor) begin
                    res_d.fault = 1'b1;
                    res_d.cause = CAUSE_RANGE;
                end else if (in_el0 && ctl.el0_block) begin
                    res_d.fault = 1'b1;
                    res_d.cause = CAUSE_EL0_BLK;
                end else if (!in_tlb_hit) begin
                    if (ctl.walk_off) begin
                        res_d.fault = 1'b1;
                        res_d.cause = CAUSE_WALK_OFF;
                    end else if (kind == ACC_NOFAULT && ctl.nf_walk_off) begin
                        res_d.nf_fail = 1'b1;
                    end else begin
                        res_d.walk = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign fault_valid = res_q.fault;
    assign fault_cause = res_q.cause;
    assign nf_fail     = res_q.nf_fail;
    assign walk_req    = res_q.walk;
    assign region_hi   = res_q.region_hi;
    assign out_addr    = res_q.addr;

    assert_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> region_hi == $past(in_va[SEL_BIT]));

    assert_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_addr[TAG_LSB-1:0] == $past(in_va[TAG_LSB-1:0]));

    assert_el0_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_el0 && kind != ACC_BRANCH && ctl.el0_block) |=> fault_valid);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_valid, nf_fail, walk_req}));

    assert_hit_no_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tlb_hit) |=> !walk_req);

    assert_branch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == ACC_BRANCH) |=> !(fault_valid || nf_fail || walk_req));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || fault_valid || nf_fail || walk_req));
endmodule

// File: tb/test_va_precheck.sv
`timescale 1ns/1ps
module test_va_precheck;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_va = '0;
    logic        in_el0 = 1'b0;
    logic [1:0]  in_kind = '0;
    logic        in_tlb_hit = 1'b0;
    logic [63:0] in_cfg = '0;
    logic        out_valid, fault_valid, nf_fail, walk_req, region_hi;
    logic [1:0]  fault_cause;
    logic [63:0] out_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    va_precheck i_va_precheck (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_va(in_va),
        .in_el0(in_el0), .in_kind(in_kind), .in_tlb_hit(in_tlb_hit), .in_cfg(in_cfg),
        .out_valid(out_valid), .fault_valid(fault_valid), .fault_cause(fault_cause),
        .nf_fail(nf_fail), .walk_req(walk_req), .region_hi(region_hi), .out_addr(out_addr)
    );

    typedef struct {
        logic        valid;
        logic        fault;
        logic [1:0]  cause;
        logic        nf;
        logic        walk;
        logic        hi;
        logic [63:0] addr;
        string       tag;
    } exp_t;

    exp_t pend;

    function automatic logic [63:0] mkcfg(input bit hi, input bit tag, input bit fex,
        input bit blk, input bit nfw, input bit woff, input int sz);
        logic [63:0] c = '0;
        if (!hi) begin
            c[37] = tag; c[51] = fex; c[55] = blk; c[53] = nfw; c[7] = woff;
            c[5:0] = sz[5:0];
        end else begin
            c[38] = tag; c[52] = fex; c[56] = blk; c[54] = nfw; c[23] = woff;
            c[21:16] = sz[5:0];
        end
        return c;
    endfunction

    function automatic exp_t model(input logic [63:0] va, input bit el0, input int kind,
        input bit hit, input logic [63:0] c, input string tag);
        exp_t e;
        bit h = va[55];
        bit tg   = h ? c[38] : c[37];
        bit fx   = h ? c[52] : c[51];
        bit bk   = h ? c[56] : c[55];
        bit nw   = h ? c[54] : c[53];
        bit wo   = h ? c[23] : c[7];
        int sz   = h ? int'(c[21:16]) : int'(c[5:0]);
        bit fetch = (kind == 1) || (kind == 3);
        bit drop  = tg && !(fx && fetch);
        int top   = drop ? 55 : 63;
        bit bad   = 0;
        for (int i = 64 - sz; i <= top; i++) if (va[i] != h) bad = 1;
        e.valid = 1; e.fault = 0; e.cause = 0; e.nf = 0; e.walk = 0;
        e.hi = h; e.tag = tag;
        e.addr = va;
        if (drop) for (int i = 56; i < 64; i++) e.addr[i] = h;
        if (kind != 3) begin
            if (bad) begin e.fault = 1; e.cause = 1; end
            else if (el0 && bk) begin e.fault = 1; e.cause = 2; end
            else if (!hit) begin
                if (wo) begin e.fault = 1; e.cause = 3; end
                else if (kind == 2 && nw) e.nf = 1;
                else e.walk = 1;
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        if (pend.valid) begin
            chk(pend.tag, "out_valid", 64'(out_valid), 64'd1);
            chk(pend.tag, "fault_valid", 64'(fault_valid), 64'(pend.fault));
            chk(pend.tag, "fault_cause", 64'(fault_cause), 64'(pend.cause));
            chk(pend.tag, "nf_fail", 64'(nf_fail), 64'(pend.nf));
            chk(pend.tag, "walk_req", 64'(walk_req), 64'(pend.walk));
            chk("R1", "region_hi", 64'(region_hi), 64'(pend.hi));
            chk(pend.tag, "out_addr", out_addr, pend.addr);
        end else begin
            chk("R10", "idle outputs",
                {out_valid, fault_valid, nf_fail, walk_req, region_hi, fault_cause},
                64'd0);
            chk("R10", "idle out_addr", out_addr, 64'd0);
        end
    endtask

    task automatic apply(input logic [63:0] va, input bit el0, input int kind,
        input bit hit, input logic [63:0] c, input string tag);
        @(negedge clk);
        compare();
        in_valid = 1; in_va = va; in_el0 = el0; in_kind = kind[1:0];
        in_tlb_hit = hit; in_cfg = c;
        pend = model(va, el0, kind, hit, c, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        compare();
        in_valid = 0; in_va = '0;
        pend.valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] lo16, hi16;
        pend.valid = 0; pend.tag = "R10";
        repeat (3) @(negedge clk);
        compare();                       // R10 reset state
        rst_n = 1;
        lo16 = mkcfg(0, 0, 0, 0, 0, 0, 16);
        hi16 = mkcfg(1, 0, 0, 0, 0, 0, 16);
        // R1 / R2 in range, both regions
        apply(64'h0000_1234_5678_9000, 0, 0, 1, lo16 | hi16, "R1");
        apply(64'hFFFF_8000_0000_1000, 0, 0, 1, lo16 | hi16, "R1");
        // R2 out of range
        apply(64'h0001_0000_0000_0000, 0, 0, 1, lo16 | hi16, "R2");
        apply(64'hFFFE_8000_0000_0000, 0, 0, 1, lo16 | hi16, "R2");
        apply(64'h7F00_0000_0000_0000, 0, 0, 1, mkcfg(0, 0, 0, 0, 0, 0, 0), "R2");
        apply(64'h0000_8000_0000_0000, 0, 0, 1, mkcfg(0, 0, 0, 0, 0, 0, 17), "R2");
        // R3 tag drop
        apply(64'hAB00_1234_0000_0000, 0, 0, 1, mkcfg(0, 1, 0, 0, 0, 0, 16), "R3");
        apply(64'hAB00_1234_0000_0000, 0, 0, 1, lo16, "R3");
        apply(64'h12FF_F000_0000_0000, 0, 2, 1, mkcfg(1, 1, 0, 0, 0, 0, 16), "R3");
        // R4 fetch exclusion
        apply(64'hAB00_1234_0000_0000, 0, 1, 1, mkcfg(0, 1, 1, 0, 0, 0, 16), "R4");
        apply(64'hAB00_1234_0000_0000, 0, 0, 1, mkcfg(0, 1, 1, 0, 0, 0, 16), "R4");
        apply(64'hAB00_1234_0000_0000, 0, 1, 1, mkcfg(0, 1, 0, 0, 0, 0, 16), "R4");
        // R5 unprivileged block
        apply(64'hFFFF_8000_0000_0000, 1, 0, 1, mkcfg(1, 0, 0, 1, 0, 0, 16), "R5");
        apply(64'hFFFF_8000_0000_0000, 0, 0, 1, mkcfg(1, 0, 0, 1, 0, 0, 16), "R5");
        apply(64'h0000_0000_0000_1000, 1, 0, 1, mkcfg(1, 0, 0, 1, 0, 0, 16) | lo16, "R5");
        // R6 walk disabled
        apply(64'h0000_0000_0000_1000, 0, 0, 0, mkcfg(0, 0, 0, 0, 0, 1, 16), "R6");
        apply(64'h0000_0000_0000_1000, 0, 0, 0, lo16, "R6");
        apply(64'h0000_0000_0000_1000, 0, 0, 1, mkcfg(0, 0, 0, 0, 0, 1, 16), "R6");
        // R7 non-fault walk off
        apply(64'h0000_0000_0000_2000, 0, 2, 0, mkcfg(0, 0, 0, 0, 1, 0, 16), "R7");
        apply(64'h0000_0000_0000_2000, 0, 2, 1, mkcfg(0, 0, 0, 0, 1, 0, 16), "R7");
        apply(64'h0000_0000_0000_2000, 0, 0, 0, mkcfg(0, 0, 0, 0, 1, 0, 16), "R7");
        // R8 priority
        apply(64'h0100_0000_0000_0000, 1, 2, 0, mkcfg(0, 0, 0, 1, 1, 1, 16), "R8");
        apply(64'h0000_0000_0000_0000, 1, 2, 0, mkcfg(0, 0, 0, 1, 1, 1, 16), "R8");
        apply(64'h0000_0000_0000_0000, 0, 2, 0, mkcfg(0, 0, 0, 1, 1, 1, 16), "R8");
        // R9 branch targets
        apply(64'h12FF_8000_0000_0000, 0, 3, 0, mkcfg(1, 1, 0, 1, 0, 1, 16), "R9");
        apply(64'hCD00_0000_0000_4000, 1, 3, 0, mkcfg(0, 1, 0, 1, 0, 1, 16), "R9");
        apply(64'hCD00_0000_0000_4000, 0, 3, 0, mkcfg(0, 1, 1, 0, 0, 0, 16), "R9");
        idle();
        idle();
        // R8 random mix, with idle gaps for R10
        for (int n = 0; n < 400; n++) begin
            logic [63:0] va, c;
            va = {$urandom, $urandom};
            if ($urandom_range(0, 1)) va[63:48] = {16{va[55]}};
            c = {$urandom, $urandom};
            c[5:0] = 6'($urandom_range(0, 24));
            c[21:16] = 6'($urandom_range(0, 24));
            if ($urandom_range(0, 5) == 0) idle();
            else apply(va, 1'($urandom), int'($urandom_range(0, 3)), 1'($urandom), c, "R8");
        end
        idle();
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule